// File: doc/BRIEF.md
# Two-Phase CCD Readout Sequencer

This block produces the digital clock pattern that a full-frame CCD with two-phase vertical and horizontal registers needs for one exposure. A pulse on the master-start input starts a frame. The frame first opens the shutter for an integration interval. With the shutter closed, it then moves charge down the vertical register into the horizontal register and clocks the horizontal register out pixel by pixel. The block runs from a 1 MHz master clock, so every count below is a number of master-clock cycles. The block only generates logic-level waveforms. Level shifting, the clock drivers and the sampling of the sensor output are handled elsewhere.

The block has two frame modes. Line binning issues every vertical shift back to back, which sums all rows in the horizontal register, and then reads that register once. Area scanning follows each vertical shift with a full horizontal readout. The active row count, the active pixel count and the dummy pixels around them are parameters. The integration length, the vertical pulse width and the horizontal half-period are inputs that are captured at master start. The block enforces floors on them so that the sensor's minimum pulse widths always hold. A pixel-valid strobe marks the active pixel periods for the sampling logic downstream, and a one-cycle flag marks the end of the frame.

Top module: `ccd_frame_seq`

## Requirements
- R1: While reset is asserted, and in idle after reset, the outputs hold these levels: p1v=1, p2v=0, tg=0, p1h=1, p2h=0, sg=0, rg=0, shutterOpen=0, pixValid=0, frameDone=0.
- R2: A frame starts when mstart is sampled high in idle. shutterOpen is then high for exactly max(cfgIntCnt,1) cycles, starting in the cycle that follows that clock edge. shutterOpen is never high while p2v or p2h is high.
- R3: In every cycle, tg equals p2v, sg equals p2h, p1v is the inverse of p2v, and p1h is the inverse of p2h.
- R4: A frame contains ROWS+BEVEL vertical shifts. In each shift, p2v is high for V=max(cfgVertCnt,6) cycles and p1v is then high for V cycles.
- R5: When cfgMode=0 (line binning), all vertical shifts come back to back, and a single horizontal readout follows the last one.
- R6: When cfgMode=1 (area scanning), each vertical shift is followed by one complete horizontal readout before the next shift. Vertical and horizontal pulses never overlap.
- R7: A horizontal readout has LEAD+COLS+TRAIL pixel periods. In each period, p2h is high for H=max(cfgHorzCnt,1) cycles and then low for H cycles.
- R8: rg is high for exactly one cycle per pixel period, in the first cycle of that period, which is the cycle in which p2h rises.
- R9: pixValid is high for the whole of each pixel period with index LEAD to LEAD+COLS-1, counting from 0 within a readout. It is low in all other cycles.
- R10: tg falls while p1h is high, and p1h then stays high for at least 3 cycles.
- R11: frameDone is high for one cycle directly after the last readout, and the block then returns to idle. A frame lasts I + S*2V + N*P*2H + 1 cycles, counted from the start edge. Here I is the integration length, S the shift count, P the pixels per readout, and N is 1 for binning or S for area mode.
- R12: While a frame is running, mstart pulses and changes to the cfg inputs have no effect on the current frame and do not start a further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 1 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| mstart | input | 1 | Master start; starts a frame when the block is idle |
| cfgMode | input | 1 | 0 = line binning, 1 = area scanning |
| cfgIntCnt | input | INT_W | Integration length in cycles (floor 1) |
| cfgVertCnt | input | V_W | Vertical pulse width in cycles (floor 6) |
| cfgHorzCnt | input | H_W | Horizontal half-period in cycles (floor 1) |
| p1v | output | 1 | Vertical phase 1 |
| p2v | output | 1 | Vertical phase 2 |
| tg | output | 1 | Transfer gate |
| p1h | output | 1 | Horizontal phase 1 |
| p2h | output | 1 | Horizontal phase 2 |
| sg | output | 1 | Summing gate |
| rg | output | 1 | Reset gate |
| shutterOpen | output | 1 | High during integration |
| pixValid | output | 1 | High during active pixel periods |
| frameDone | output | 1 | One-cycle end-of-frame flag |

## Verification
The assertions assume that mstart and the configuration inputs are synchronous to the master clock. They also assume that the floors of six cycles per vertical pulse and three cycles of transfer-gate overlap are fixed constants and do not depend on the values a host may program. The stimulus drives every input on the falling clock edge. It deliberately programs counts below the floors, such as a vertical width of 2 and zero for the other counts, so that the clamping paths are exercised without breaking the assumptions. The bench also pokes mstart and scrambles the configuration in the middle of a frame, so that latching at start is tested under the same assumptions.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_INTEG,
    SEQ_VSHIFT,
    SEQ_HREAD,
    SEQ_DONE
  } seqState_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic load;      // capture configuration
    logic clear;     // restart segment counters
    logic runInteg;  // integration segment active
    logic runVert;   // vertical shift segment active
    logic runHorz;   // horizontal readout segment active
    logic rowInc;    // one vertical shift completed
    logic rowClr;    // reset shift counter
    logic done;      // end-of-frame cycle
  } seqStrobe_t;

  // counter comparisons reported back to the control FSM
  typedef struct packed {
    logic intEnd;
    logic vEnd;
    logic hEnd;
    logic rowLast;
    logic rowsDone;
    logic areaMode;
  } seqFlag_t;

endpackage

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mstart,
  input  seqFlag_t   flags,
  output seqStrobe_t strobes
);

  seqState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strobes  = '0;
    stateNxt = state;
    unique case (state)
      SEQ_IDLE: begin
        if (mstart) begin
          strobes.load  = 1'b1;
          strobes.clear = 1'b1;
          stateNxt      = SEQ_INTEG;
        end
      end
      SEQ_INTEG: begin
        strobes.runInteg = 1'b1;
        if (flags.intEnd) begin
          strobes.clear  = 1'b1;
          strobes.rowClr = 1'b1;
          stateNxt       = SEQ_VSHIFT;
        end
      end
      SEQ_VSHIFT: begin
        strobes.runVert = 1'b1;
        if (flags.vEnd) begin
          strobes.clear  = 1'b1;
          strobes.rowInc = 1'b1;
          // binning keeps shifting until the last row; area reads every row
          if (!flags.areaMode && !flags.rowLast) stateNxt = SEQ_VSHIFT;
          else                                   stateNxt = SEQ_HREAD;
        end
      end
      SEQ_HREAD: begin
        strobes.runHorz = 1'b1;
        if (flags.hEnd) begin
          strobes.clear = 1'b1;
          stateNxt      = flags.rowsDone ? SEQ_DONE : SEQ_VSHIFT;
        end
      end
      SEQ_DONE: begin
        strobes.done = 1'b1;
        stateNxt     = SEQ_IDLE;
      end
      default: stateNxt = SEQ_IDLE;
    endcase
  end

endmodule

// File: rtl/ccd_seq_dpath.sv
module ccd_seq_dpath
  import ccd_seq_pkg::*;
#(
  parameter int ROWS  = 58,
  parameter int COLS  = 512,
  parameter int LEAD  = 10,
  parameter int TRAIL = 10,
  parameter int BEVEL = 6,
  parameter int INT_W = 16,
  parameter int V_W   = 8,
  parameter int H_W   = 8,
  parameter int V_MIN = 6
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMode,
  input  logic [INT_W-1:0] cfgIntCnt,
  input  logic [V_W-1:0]   cfgVertCnt,
  input  logic [H_W-1:0]   cfgHorzCnt,
  input  seqStrobe_t       strobes,
  output seqFlag_t         flags,
  output logic             p1v,
  output logic             p2v,
  output logic             tg,
  output logic             p1h,
  output logic             p2h,
  output logic             sg,
  output logic             rg,
  output logic             shutterOpen,
  output logic             pixValid,
  output logic             frameDone
);

  localparam int ROWS_TOTAL = ROWS + BEVEL;
  localparam int PIX_TOTAL  = LEAD + COLS + TRAIL;
  localparam int ROW_W      = $clog2(ROWS_TOTAL + 1);
  localparam int PIX_W      = $clog2(PIX_TOTAL);
  localparam int TICK_W     = (INT_W > V_W) ? ((INT_W > H_W) ? INT_W : H_W)
                                            : ((V_W > H_W) ? V_W : H_W);
  localparam logic [V_W-1:0] V_FLOOR = V_W'(V_MIN);

  typedef logic [TICK_W-1:0] tick_t;

  logic [INT_W-1:0] intLenQ;
  logic [V_W-1:0]   vWidQ;
  logic [H_W-1:0]   hHalfQ;
  logic             areaQ;

  tick_t            tick;
  logic             half;
  logic [PIX_W-1:0] pixIdx;
  logic [ROW_W-1:0] rowCnt;

  logic tickEndInt, tickEndV, tickEndH, pixLast, pixActive;
  logic vHigh, hHigh;

  // configuration capture with floors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intLenQ <= INT_W'(1);
      vWidQ   <= V_FLOOR;
      hHalfQ  <= H_W'(1);
      areaQ   <= 1'b0;
    end else if (strobes.load) begin
      intLenQ <= (cfgIntCnt == '0) ? INT_W'(1) : cfgIntCnt;
      vWidQ   <= (cfgVertCnt < V_FLOOR) ? V_FLOOR : cfgVertCnt;
      hHalfQ  <= (cfgHorzCnt == '0) ? H_W'(1) : cfgHorzCnt;
      areaQ   <= cfgMode;
    end
  end

  assign tickEndInt = (tick == tick_t'(intLenQ) - tick_t'(1));
  assign tickEndV   = (tick == tick_t'(vWidQ) - tick_t'(1));
  assign tickEndH   = (tick == tick_t'(hHalfQ) - tick_t'(1));
  assign pixLast    = (pixIdx == PIX_W'(PIX_TOTAL - 1));

  // shared segment counter: tick within a half, half select, pixel index
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      tick   <= '0;
      half   <= 1'b0;
      pixIdx <= '0;
    end else if (strobes.runInteg) begin
      tick <= tick + tick_t'(1);
    end else if (strobes.runVert) begin
      if (tickEndV) begin
        tick <= '0;
        half <= ~half;
      end else begin
        tick <= tick + tick_t'(1);
      end
    end else if (strobes.runHorz) begin
      if (tickEndH) begin
        tick <= '0;
        half <= ~half;
        if (half) pixIdx <= pixIdx + PIX_W'(1);
      end else begin
        tick <= tick + tick_t'(1);
      end
    end
  end

  // vertical shift counter
  always_ff @(posedge clk) begin
    if (!rstN || strobes.rowClr) rowCnt <= '0;
    else if (strobes.rowInc)     rowCnt <= rowCnt + ROW_W'(1);
  end

  // active window decode, variant picked by the leading dummy count
  generate
    if (LEAD == 0) begin : g_noLead
      assign pixActive = (pixIdx < PIX_W'(COLS));
    end else begin : g_lead
      assign pixActive = (pixIdx >= PIX_W'(LEAD)) && (pixIdx < PIX_W'(LEAD + COLS));
    end
  endgenerate

  assign flags.intEnd   = tickEndInt;
  assign flags.vEnd     = half && tickEndV;
  assign flags.hEnd     = half && tickEndH && pixLast;
  assign flags.rowLast  = (rowCnt == ROW_W'(ROWS_TOTAL - 1));
  assign flags.rowsDone = (rowCnt == ROW_W'(ROWS_TOTAL));
  assign flags.areaMode = areaQ;

  // waveform decode
  assign vHigh       = strobes.runVert && !half;
  assign hHigh       = strobes.runHorz && !half;
  assign p2v         = vHigh;
  assign p1v         = ~vHigh;
  assign tg          = vHigh;
  assign p2h         = hHigh;
  assign p1h         = ~hHigh;
  assign sg          = hHigh;
  assign rg          = hHigh && (tick == '0);
  assign pixValid    = strobes.runHorz && pixActive;
  assign shutterOpen = strobes.runInteg;
  assign frameDone   = strobes.done;

endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
  import ccd_seq_pkg::*;
#(
  parameter int ROWS  = 58,
  parameter int COLS  = 512,
  parameter int LEAD  = 10,
  parameter int TRAIL = 10,
  parameter int BEVEL = 6,
  parameter int INT_W = 16,
  parameter int V_W   = 8,
  parameter int H_W   = 8,
  parameter int V_MIN = 6
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             mstart,
  input  logic             cfgMode,
  input  logic [INT_W-1:0] cfgIntCnt,
  input  logic [V_W-1:0]   cfgVertCnt,
  input  logic [H_W-1:0]   cfgHorzCnt,
  output logic             p1v,
  output logic             p2v,
  output logic             tg,
  output logic             p1h,
  output logic             p2h,
  output logic             sg,
  output logic             rg,
  output logic             shutterOpen,
  output logic             pixValid,
  output logic             frameDone
);

  seqStrobe_t strobes;
  seqFlag_t   flags;

  ccd_seq_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .mstart  (mstart),
    .flags   (flags),
    .strobes (strobes)
  );

  ccd_seq_dpath #(
    .ROWS(ROWS), .COLS(COLS), .LEAD(LEAD), .TRAIL(TRAIL), .BEVEL(BEVEL),
    .INT_W(INT_W), .V_W(V_W), .H_W(H_W), .V_MIN(V_MIN)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .cfgMode     (cfgMode),
    .cfgIntCnt   (cfgIntCnt),
    .cfgVertCnt  (cfgVertCnt),
    .cfgHorzCnt  (cfgHorzCnt),
    .strobes     (strobes),
    .flags       (flags),
    .p1v         (p1v),
    .p2v         (p2v),
    .tg          (tg),
    .p1h         (p1h),
    .p2h         (p2h),
    .sg          (sg),
    .rg          (rg),
    .shutterOpen (shutterOpen),
    .pixValid    (pixValid),
    .frameDone   (frameDone)
  );

endmodule

// File: rtl/ccd_seq_checker.sv
module ccd_seq_checker #(
  parameter int V_MIN   = 6,
  parameter int OVL_MIN = 3
)(
  input logic clk,
  input logic rstN,
  input logic tg,
  input logic p1h,
  input logic p2v,
  input logic p2h,
  input logic rg,
  input logic shutterOpen,
  input logic pixValid,
  input logic frameDone
);

  logic [7:0] vRun;
  logic [7:0] sinceTg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vRun    <= '0;
      sinceTg <= '0;
    end else begin
      vRun    <= p2v ? ((vRun == 8'hFF) ? vRun : vRun + 8'd1) : 8'd0;
      sinceTg <= tg  ? 8'd0 : ((sinceTg == 8'hFF) ? sinceTg : sinceTg + 8'd1);
    end
  end

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (!shutterOpen && !p2v && !p2h && !pixValid));  // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);  // R11
  AST_SHUTTER_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (p2v || p2h) |-> !shutterOpen);  // R2
  AST_V_H_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    p2v |-> !p2h);  // R6
  AST_VPULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(p2v) |-> (vRun >= 8'(V_MIN)));  // R4
  AST_TG_FALL_P1H: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tg) |-> p1h);  // R10
  AST_TG_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(p2h) |-> (sinceTg >= 8'(OVL_MIN)));  // R10
  AST_RG_IN_P2H: assert property (@(posedge clk) disable iff (!rstN)
    rg |-> p2h);  // R8
  AST_RG_AT_PIXEL_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(p2h) |-> rg);  // R8
  AST_PIXVALID_READOUT: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (!shutterOpen && !p2v));  // R9

endmodule

bind ccd_frame_seq ccd_seq_checker #(.V_MIN(V_MIN), .OVL_MIN(3)) i_ccd_seq_checker (.*);

// File: tb/test_ccd_frame_seq.sv
module test_ccd_frame_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 2;
  localparam int COLS  = 4;
  localparam int LEAD  = 10;
  localparam int TRAIL = 10;
  localparam int BEVEL = 6;
  localparam int RT    = ROWS + BEVEL;
  localparam int P     = LEAD + COLS + TRAIL;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mstart = 1'b0;
  logic        cfgMode = 1'b0;
  logic [15:0] cfgIntCnt = '0;
  logic [7:0]  cfgVertCnt = '0;
  logic [7:0]  cfgHorzCnt = '0;
  logic p1v, p2v, tg, p1h, p2h, sg, rg, shutterOpen, pixValid, frameDone;

  int nChecks = 0;
  int nErr    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_frame_seq #(.ROWS(ROWS), .COLS(COLS), .LEAD(LEAD), .TRAIL(TRAIL), .BEVEL(BEVEL))
  i_ccd_frame_seq (
    .clk(clk), .rstN(rstN), .mstart(mstart), .cfgMode(cfgMode),
    .cfgIntCnt(cfgIntCnt), .cfgVertCnt(cfgVertCnt), .cfgHorzCnt(cfgHorzCnt),
    .p1v(p1v), .p2v(p2v), .tg(tg), .p1h(p1h), .p2h(p2h), .sg(sg), .rg(rg),
    .shutterOpen(shutterOpen), .pixValid(pixValid), .frameDone(frameDone)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, "idle levels", {p1v, p2v, tg, p1h, p2h, sg, rg, shutterOpen, pixValid, frameDone},
          10'b1001000000);
  endtask

  task automatic runFrame(input int mode, input int iCnt, input int vCnt, input int hCnt, input bit poke);
    int ix, vx, hx, nReads, expLen, cyc;
    int shutCnt, p2vHigh, p2vRise, p2hHigh, p2hRise, rgHigh, pvHigh, vRun, hRun, ovlRun;
    int compBad, orderBad, vWidBad, hWidBad, rgBad, pvBad, ovlBad, idleBad;
    bit pP2v, pP2h, pTg, pPv, ovlOn, p2hRose;
    ix = (iCnt == 0) ? 1 : iCnt;
    vx = (vCnt < 6) ? 6 : vCnt;
    hx = (hCnt == 0) ? 1 : hCnt;
    nReads = (mode == 1) ? RT : 1;
    expLen = ix + RT * 2 * vx + nReads * P * 2 * hx + 1;
    {shutCnt, p2vHigh, p2vRise, p2hHigh, p2hRise, rgHigh, pvHigh, vRun, hRun, ovlRun} = '0;
    {compBad, orderBad, vWidBad, hWidBad, rgBad, pvBad, ovlBad, idleBad} = '0;
    {pP2v, pP2h, pTg, pPv, ovlOn} = '0;
    cfgMode = mode[0]; cfgIntCnt = 16'(iCnt); cfgVertCnt = 8'(vCnt); cfgHorzCnt = 8'(hCnt);
    mstart = 1'b1;
    @(negedge clk);
    mstart = 1'b0;
    cyc = 0;
    forever begin
      cyc++;
      if (shutterOpen) shutCnt++;
      if (p1v == p2v || tg != p2v || sg != p2h || p1h == p2h) compBad++;
      if (p2v) begin p2vHigh++; vRun++; end
      if (p2v && !pP2v) begin
        if (p2hRise != ((mode == 1) ? p2vRise * P : 0)) orderBad++;
        p2vRise++;
      end
      if (!p2v && pP2v) begin
        if (vRun != vx) vWidBad++;
        vRun = 0;
      end
      p2hRose = p2h && !pP2h;
      if (p2h) begin p2hHigh++; hRun++; end
      if (p2hRose) begin
        if (mode == 0 && p2vRise != RT) orderBad++;
        if (mode == 1 && p2vRise != p2hRise / P + 1) orderBad++;
        p2hRise++;
      end
      if (!p2h && pP2h) begin
        if (hRun != hx) hWidBad++;
        hRun = 0;
      end
      if (rg) begin
        rgHigh++;
        if (!p2hRose) rgBad++;
      end
      if (pixValid) pvHigh++;
      if (pixValid && !pPv) begin
        if (!p2hRose || ((p2hRise - 1) % P) != LEAD) pvBad++;
      end
      if (pTg && !tg) begin
        if (!p1h) ovlBad++;
        ovlOn = 1'b1; ovlRun = 0;
      end
      if (ovlOn) begin
        if (p1h) ovlRun++;
        else begin
          if (ovlRun < 3) ovlBad++;
          ovlOn = 1'b0;
        end
      end
      pP2v = p2v; pP2h = p2h; pTg = tg; pPv = pixValid;
      if (frameDone || cyc >= LIMIT) break;
      if (poke && cyc == 20) begin
        mstart = 1'b1; cfgMode = ~cfgMode; cfgIntCnt = 16'hFFFF;
        cfgVertCnt = 8'hFF; cfgHorzCnt = 8'hFF;
      end
      if (poke && cyc == 21) mstart = 1'b0;
      @(negedge clk);
    end
    check("R11", "frame length", cyc, expLen);
    check("R2",  "shutter cycles", shutCnt, ix);
    check("R4",  "vertical shift count", p2vRise, RT);
    check("R4",  "p2v high cycles", p2vHigh, RT * vx);
    check("R4",  "p2v pulse width errors", vWidBad, 0);
    check("R3",  "phase relation errors", compBad, 0);
    check(mode == 1 ? "R6" : "R5", "shift/readout order errors", orderBad, 0);
    check("R7",  "pixel periods", p2hRise, nReads * P);
    check("R7",  "p2h high cycles", p2hHigh, nReads * P * hx);
    check("R7",  "p2h pulse width errors", hWidBad, 0);
    check("R8",  "rg pulses", rgHigh, nReads * P);
    check("R8",  "rg misplaced", rgBad, 0);
    check("R9",  "pixValid cycles", pvHigh, nReads * COLS * 2 * hx);
    check("R9",  "pixValid position errors", pvBad, 0);
    check("R10", "tg/p1h overlap errors", ovlBad, 0);
    // R12: no second frame after a mid-frame start pulse; outputs idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (shutterOpen || p2v || p2h || frameDone) idleBad++;
    end
    check(poke ? "R12" : "R11", "activity after done", idleBad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL R11 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int vList[3] = '{2, 6, 7};
    int hList[3] = '{0, 1, 2};
    int iList[2] = '{0, 3};
    repeat (3) @(negedge clk);
    checkIdle("R1");
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1");
    for (int m = 0; m < 2; m++)
      for (int vi = 0; vi < 3; vi++)
        for (int hi = 0; hi < 3; hi++)
          for (int ii = 0; ii < 2; ii++)
            runFrame(m, iList[ii], vList[vi], hList[hi], (vi == 1) && (ii == 1));
    checkIdle("R1");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule